// File: doc/BRIEF.md
# Wavefront Instruction Fetch Arbiter

This block sits in front of an instruction memory path and decides, one slot at a time, which of N hardware wavefront slots may issue its next instruction fetch. Every cycle it looks at each slot's live state: whether the slot is running, how many instructions its buffer holds, whether any buffered instruction is a branch, and whether a fetch is already outstanding for it. A slot that passes all of these tests joins a first-in first-out ready queue. The queue guarantees that no slot appears in it twice.

When the outgoing request register is free, the oldest queued slot is taken from the queue. Its fetch address is computed as base pointer plus program counter plus the byte size of the instructions it already holds. This skips over what is already buffered. The request length stops at the end of the cache line holding that address. The request is offered on a valid/ready port. A refused request stays in the register unchanged and is offered again until it is taken, and no other slot is selected in the meantime.

After selection the slot is marked as having a fetch pending. It is not considered again until a return-complete pulse carrying its slot ID clears that mark. Because a slot with a branch in its buffer is never eligible, nothing is fetched speculatively past a branch.

Top module: `wf_fetch_arbiter`

## Requirements
- R1: A slot is eligible only when all of these hold: its running input is 1, its buffer occupancy is at most BUF_LIMIT (default 4), its branch flag is 0, and it has no fetch pending. A slot that fails any of these tests produces no request.
- R2: A slot is held in the ready queue at most once. A slot that stays eligible while it is queued produces exactly one request.
- R3: Requests are issued oldest-first in ready-queue order. Slots that become eligible in the same cycle enter the queue in ascending slot-ID order.
- R4: When the ready queue is empty, no new request is raised.
- R5: Selecting a slot sets its pending flag and removes it from the queue. The slot gets no further request until a cycle with ret_valid=1 and ret_slot equal to its ID.
- R6: req_addr equals base + pc + buffered byte total of the selected slot, modulo 2^32, using the input values in the cycle the slot is selected.
- R7: req_len equals LINE_BYTES (default 64) when req_addr is a multiple of LINE_BYTES. Otherwise it equals LINE_BYTES minus (req_addr mod LINE_BYTES), so a request never crosses a line.
- R8: While req_valid=1 and req_ready=0, req_valid, req_slot, req_addr and req_len stay unchanged, and no other slot is selected.
- R9: During and directly after a synchronous active-low reset, req_valid is 0, the queue is empty and no slot is pending.
- R10: A slot that becomes eligible in cycle k, with an empty queue and a free output, shows its request after the second rising edge. When a request is accepted, the next queued slot is presented in the following cycle with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| slot_running | input | N | Per-slot running status |
| slot_occ | input | N*OCC_W | Per-slot instruction buffer occupancy |
| slot_branch | input | N | Per-slot flag: a buffered instruction is a branch |
| slot_pc | input | N*32 | Per-slot program counter |
| slot_base | input | N*32 | Per-slot base pointer |
| slot_buf_bytes | input | N*BYTES_W | Per-slot total byte size of buffered instructions |
| ret_valid | input | 1 | Fetch return complete pulse |
| ret_slot | input | SID_W | Slot ID of the completed fetch |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_slot | output | SID_W | Slot ID of the request |
| req_addr | output | 32 | Fetch byte address |
| req_len | output | LEN_W | Fetch length in bytes |

## Verification
The assertions check four things on every cycle: a refused request holds steady, a request never runs past its line end, the number of queued flags matches the queue count (so no slot appears twice), and an empty queue with a free output raises nothing. They also check that a selection marks its slot pending and unqueued. Other behaviours can only be shown by the bench's scenarios. These are the full eligibility truth table per slot, the exact address arithmetic including wrap-around, the length at every line offset, the oldest-first order among slots that arrive together or at different times, and re-fetch only after a matching return pulse.

// File: rtl/fa_pkg.sv
// Shared constants and helpers for the fetch arbiter.
// Assumes a 32-bit byte address space.
package fa_pkg;
    localparam int ADDR_W = 32;
    typedef logic [ADDR_W-1:0] addr_t;
endpackage

// File: rtl/fa_eligibility.sv
// Per-slot eligibility test and enqueue request generation.
// Assumes occupancy is an unsigned count and that all flags are registered upstream.
module fa_eligibility #(
    parameter int N         = 4,
    parameter int OCC_W     = 4,
    parameter int BUF_LIMIT = 4
) (
    input  logic [N-1:0]       running,
    input  logic [N*OCC_W-1:0] occ,
    input  logic [N-1:0]       branch,
    input  logic [N-1:0]       pending,
    input  logic [N-1:0]       queued,
    output logic [N-1:0]       push_vec
);
    logic [N-1:0] eligible;

    for (genvar g = 0; g < N; g++) begin : g_slot
        // Slot may fetch: running, room in buffer, no branch, nothing outstanding
        assign eligible[g] = running[g] && !branch[g] && !pending[g]
                             && (int'(occ[g*OCC_W +: OCC_W]) <= BUF_LIMIT);
        // Enqueue only slots not already waiting in the queue
        assign push_vec[g] = eligible[g] && !queued[g];
    end
endmodule

// File: rtl/fa_ready_queue.sv
// FIFO of slot IDs with one pop and up to N pushes per cycle.
// Pushes in one cycle enter in ascending slot order after any pop.
// Assumes the caller never pushes a slot that is already held, so depth N cannot overflow.
module fa_ready_queue #(
    parameter int N     = 4,
    parameter int SID_W = 2,
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     push_vec,
    input  logic             pop,
    output logic [SID_W-1:0] head,
    output logic [CNT_W-1:0] count
);
    logic [SID_W-1:0] q     [N];
    logic [SID_W-1:0] q_nxt [N];
    logic [CNT_W-1:0] cnt_nxt;

    // Next queue contents: shift out the head on pop, then append new slots
    always_comb begin
        q_nxt   = q;
        cnt_nxt = count;
        if (pop && count != '0) begin
            for (int i = 0; i < N - 1; i++) q_nxt[i] = q[i+1];
            q_nxt[N-1] = '0;
            cnt_nxt    = count - CNT_W'(1);
        end
        for (int j = 0; j < N; j++) begin
            if (push_vec[j]) begin
                if (int'(cnt_nxt) < N) q_nxt[cnt_nxt[SID_W-1:0]] = SID_W'(j);
                cnt_nxt = cnt_nxt + CNT_W'(1);
            end
        end
    end

    // Queue storage and occupancy registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) q[i] <= '0;
            count <= '0;
        end else begin
            q     <= q_nxt;
            count <= cnt_nxt;
        end
    end

    assign head = q[0];
endmodule

// File: rtl/fa_req_builder.sv
// Builds the fetch address and line-bounded length for the selected slot.
// Assumes LINE_BYTES is a power of two; the address wraps modulo 2^32.
module fa_req_builder
    import fa_pkg::*;
#(
    parameter int N          = 4,
    parameter int SID_W      = 2,
    parameter int BYTES_W    = 8,
    parameter int LINE_BYTES = 64,
    localparam int LINE_LOG  = $clog2(LINE_BYTES),
    localparam int LEN_W     = LINE_LOG + 1
) (
    input  logic [SID_W-1:0]     sel,
    input  logic [N*ADDR_W-1:0]  base,
    input  logic [N*ADDR_W-1:0]  pc,
    input  logic [N*BYTES_W-1:0] buf_bytes,
    output addr_t                addr,
    output logic [LEN_W-1:0]     len
);
    logic [LINE_LOG-1:0] offset;

    // Address skips the instructions already buffered for this slot
    always_comb begin
        addr = base[int'(sel)*ADDR_W +: ADDR_W] + pc[int'(sel)*ADDR_W +: ADDR_W]
             + ADDR_W'(buf_bytes[int'(sel)*BYTES_W +: BYTES_W]);
    end

    assign offset = addr[LINE_LOG-1:0];

    // Length runs to the end of the current line
    always_comb begin
        if (offset == '0) len = LEN_W'(LINE_BYTES);
        else              len = LEN_W'(LINE_BYTES) - LEN_W'(offset);
    end
endmodule

// File: rtl/wf_fetch_arbiter.sv
// Top of the wavefront fetch arbiter. Queues eligible slots oldest-first,
// selects one whenever the output register is free, tracks pending fetches
// per slot, and holds a refused request until the downstream accepts it.
// Assumes ret_slot names a slot with a fetch pending when ret_valid is 1.
module wf_fetch_arbiter
    import fa_pkg::*;
#(
    parameter int N          = 4,
    parameter int OCC_W      = 4,
    parameter int BUF_LIMIT  = 4,
    parameter int BYTES_W    = 8,
    parameter int LINE_BYTES = 64,
    localparam int SID_W     = (N > 1) ? $clog2(N) : 1,
    localparam int CNT_W     = $clog2(N + 1),
    localparam int LEN_W     = $clog2(LINE_BYTES) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         slot_running,
    input  logic [N*OCC_W-1:0]   slot_occ,
    input  logic [N-1:0]         slot_branch,
    input  logic [N*32-1:0]      slot_pc,
    input  logic [N*32-1:0]      slot_base,
    input  logic [N*BYTES_W-1:0] slot_buf_bytes,
    input  logic                 ret_valid,
    input  logic [SID_W-1:0]     ret_slot,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [SID_W-1:0]     req_slot,
    output logic [31:0]          req_addr,
    output logic [LEN_W-1:0]     req_len
);
    logic [N-1:0]     pending, queued, push_vec, sel_mask, ret_mask;
    logic [SID_W-1:0] head;
    logic [CNT_W-1:0] q_count;
    logic             pop;
    addr_t            nxt_addr;
    logic [LEN_W-1:0] nxt_len;

    fa_eligibility #(.N(N), .OCC_W(OCC_W), .BUF_LIMIT(BUF_LIMIT)) u_elig (
        .running (slot_running),
        .occ     (slot_occ),
        .branch  (slot_branch),
        .pending (pending),
        .queued  (queued),
        .push_vec(push_vec)
    );

    fa_ready_queue #(.N(N), .SID_W(SID_W), .CNT_W(CNT_W)) u_queue (
        .clk     (clk),
        .rst_n   (rst_n),
        .push_vec(push_vec),
        .pop     (pop),
        .head    (head),
        .count   (q_count)
    );

    fa_req_builder #(.N(N), .SID_W(SID_W), .BYTES_W(BYTES_W),
                     .LINE_BYTES(LINE_BYTES)) u_build (
        .sel      (head),
        .base     (slot_base),
        .pc       (slot_pc),
        .buf_bytes(slot_buf_bytes),
        .addr     (nxt_addr),
        .len      (nxt_len)
    );

    // Select the queue head whenever the output register is empty or draining
    assign pop      = (q_count != '0) && (!req_valid || req_ready);
    assign sel_mask = pop ? (N'(1) << head) : '0;
    assign ret_mask = ret_valid ? (N'(1) << ret_slot) : '0;

    // Per-slot pending and queued flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            queued  <= '0;
        end else begin
            pending <= (pending & ~ret_mask) | sel_mask;
            queued  <= (queued | push_vec) & ~sel_mask;
        end
    end

    // Output request register: load on selection, hold while refused
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_slot  <= '0;
            req_addr  <= '0;
            req_len   <= '0;
        end else if (pop) begin
            req_valid <= 1'b1;
            req_slot  <= head;
            req_addr  <= nxt_addr;
            req_len   <= nxt_len;
        end else if (req_ready) begin
            req_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/fa_checker.sv
// Property checker for the fetch arbiter, attached by bind.
// Observes ports and the queue/flag state; drives nothing.
module fa_checker #(
    parameter int N          = 4,
    parameter int SID_W      = 2,
    parameter int CNT_W      = 3,
    parameter int LINE_BYTES = 64,
    localparam int LINE_LOG  = $clog2(LINE_BYTES),
    localparam int LEN_W     = LINE_LOG + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [SID_W-1:0] req_slot,
    input logic [31:0]      req_addr,
    input logic [LEN_W-1:0] req_len,
    input logic [CNT_W-1:0] q_count,
    input logic [N-1:0]     queued,
    input logic [N-1:0]     pending,
    input logic             pop,
    input logic [SID_W-1:0] head
);
    // R8: a refused request holds all fields
    a_r8_hold_refused: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_slot)
                                    && $stable(req_addr) && $stable(req_len));

    // R7: request ends exactly at the line boundary
    a_r7_line_end: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (LEN_W'(req_addr[LINE_LOG-1:0]) + req_len) == LEN_W'(LINE_BYTES));

    // R2: queue count agrees with the set of queued flags
    a_r2_no_duplicate: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(queued) == int'(q_count));

    // R4: nothing queued and output idle means no request next cycle
    a_r4_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid && q_count == '0 |=> !req_valid);

    // R5: a selection marks the slot pending and takes it out of the queue
    a_r5_select_marks: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> pending[$past(head)] && !queued[$past(head)]);

    // R9: reset leaves no request standing
    a_r9_reset_idle: assert property (@(posedge clk)
        !rst_n |=> !req_valid);
endmodule

bind wf_fetch_arbiter fa_checker #(
    .N(N), .SID_W(SID_W), .CNT_W(CNT_W), .LINE_BYTES(LINE_BYTES)
) u_fa_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_slot (req_slot),
    .req_addr (req_addr),
    .req_len  (req_len),
    .q_count  (q_count),
    .queued   (queued),
    .pending  (pending),
    .pop      (pop),
    .head     (head)
);

// File: tb/tb_wf_fetch_arbiter.sv
// Self-checking bench: sweeps eligibility per slot, line offsets and queue order.
module tb_wf_fetch_arbiter;
    localparam int N = 4, OCC_W = 4, BYTES_W = 8, LINE = 64, SID_W = 2, LEN_W = 7;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [N-1:0]         running = '0, branch = '0;
    logic [N*OCC_W-1:0]   occ = '0;
    logic [N*32-1:0]      pc = '0, base = '0;
    logic [N*BYTES_W-1:0] bytes = '0;
    logic                 ret_valid = 1'b0, req_ready = 1'b0;
    logic [SID_W-1:0]     ret_slot = '0;
    logic                 req_valid;
    logic [SID_W-1:0]     req_slot;
    logic [31:0]          req_addr;
    logic [LEN_W-1:0]     req_len;

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    wf_fetch_arbiter #(.N(N), .OCC_W(OCC_W), .BUF_LIMIT(4), .BYTES_W(BYTES_W),
                       .LINE_BYTES(LINE)) dut (
        .clk(clk), .rst_n(rst_n), .slot_running(running), .slot_occ(occ),
        .slot_branch(branch), .slot_pc(pc), .slot_base(base),
        .slot_buf_bytes(bytes), .ret_valid(ret_valid), .ret_slot(ret_slot),
        .req_valid(req_valid), .req_ready(req_ready), .req_slot(req_slot),
        .req_addr(req_addr), .req_len(req_len)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_slot(input int s, input logic run, input logic [3:0] o,
                            input logic br, input logic [31:0] p,
                            input logic [31:0] b, input logic [7:0] by);
        running[s] = run;
        occ[s*OCC_W +: OCC_W] = o;
        branch[s] = br;
        pc[s*32 +: 32] = p;
        base[s*32 +: 32] = b;
        bytes[s*BYTES_W +: BYTES_W] = by;
    endtask

    function automatic logic [31:0] exp_len(input logic [31:0] a);
        return (a % LINE == 0) ? LINE : LINE - (a % LINE);
    endfunction

    // Present one slot, check its request two edges later, then retire it
    task automatic one_vector(input string req, input int s, input logic run,
                              input logic [3:0] o, input logic br,
                              input logic [31:0] p, input logic [31:0] b,
                              input logic [7:0] by);
        logic        elig;
        logic [31:0] a;
        elig = run && (o <= 4) && !br;
        a = b + p + {24'd0, by};
        set_slot(s, run, o, br, p, b, by);
        req_ready = 1'b1;
        tick(2);
        chk({req, " valid"}, {31'd0, req_valid}, {31'd0, elig});
        if (elig) begin
            chk({req, " slot"}, {30'd0, req_slot}, s);
            chk({req, " addr R6"}, req_addr, a);
            chk({req, " len R7"}, {25'd0, req_len}, exp_len(a));
        end
        running[s] = 1'b0;
        tick(1);
        ret_valid = 1'b1; ret_slot = SID_W'(s);
        tick(1);
        ret_valid = 1'b0;
        tick(1);
        chk({req, " drained R4"}, {31'd0, req_valid}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int vi;
        vi = 0;
        // R9: reset state
        tick(3);
        chk("R9 reset valid", {31'd0, req_valid}, 32'd0);
        rst_n = 1'b1;
        tick(1);
        chk("R9 after reset", {31'd0, req_valid}, 32'd0);

        // R1 R6 R7 R10: eligibility truth table per slot with varied addresses
        for (int s = 0; s < N; s++)
            for (int o = 0; o < 7; o++)
                for (int br = 0; br < 2; br++)
                    for (int run = 0; run < 2; run++) begin
                        vi++;
                        one_vector("R1 R10 sweep", s, run[0], o[3:0], br[0],
                                   vi * 36, 32'h0001_0000 * (s + 1) + vi * 3,
                                   8'((vi * 12) % 256));
                    end

        // R7: every line offset
        for (int off = 0; off < LINE; off++)
            one_vector("R7 offset", 3, 1'b1, 4'd2, 1'b0, 32'h0, 32'h2000 + off, 8'd0);

        // R6: address wraps modulo 2^32
        one_vector("R6 wrap", 1, 1'b1, 4'd4, 1'b0, 32'h20, 32'hFFFF_FFF0, 8'd4);

        // R3 R8: queue order with output stalled
        req_ready = 1'b0;
        set_slot(2, 1'b1, 0, 1'b0, 32'h200, 32'h0, 8'd0);
        tick(1);
        set_slot(3, 1'b1, 0, 1'b0, 32'h300, 32'h0, 8'd0);
        set_slot(0, 1'b1, 0, 1'b0, 32'h100, 32'h0, 8'd8);
        tick(1);
        set_slot(1, 1'b1, 0, 1'b0, 32'h180, 32'h0, 8'd0);
        tick(2);
        chk("R8 held valid", {31'd0, req_valid}, 32'd1);
        chk("R3 first slot", {30'd0, req_slot}, 32'd2);
        tick(3);
        chk("R8 held slot", {30'd0, req_slot}, 32'd2);
        chk("R8 held addr", req_addr, 32'h200);
        req_ready = 1'b1;
        tick(1);
        chk("R3 R10 second slot", {30'd0, req_slot}, 32'd0);
        chk("R6 second addr", req_addr, 32'h108);
        tick(1);
        chk("R3 third slot", {30'd0, req_slot}, 32'd3);
        tick(1);
        chk("R3 fourth slot", {30'd0, req_slot}, 32'd1);
        tick(1);
        chk("R2 no repeat", {31'd0, req_valid}, 32'd0);
        tick(3);
        chk("R5 no refetch while pending", {31'd0, req_valid}, 32'd0);
        ret_valid = 1'b1; ret_slot = 2'd0;
        tick(1);
        ret_valid = 1'b0;
        tick(2);
        chk("R5 refetch after return", {31'd0, req_valid}, 32'd1);
        chk("R5 refetch slot", {30'd0, req_slot}, 32'd0);
        running = '0;
        tick(2);
        chk("R4 idle at end", {31'd0, req_valid}, 32'd0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule